// File: doc/BRIEF.md
# Failsafe Idle Polarity Latch

This block lets a bus node work out, without any training exchange, that its two differential conductors were swapped during installation. The controlling node biases the idle bus to a known failsafe level. A node wired the right way round then reads a high receiver output whenever nobody drives, and a swapped node reads a steady low. Normal frames also produce lows: a start bit followed by eight zero data bits gives nine low bit times in a row. A low is therefore treated as failsafe idle only when it lasts longer than a limit, set above that longest legal data run plus one or two guard bits of margin for jitter.

The receiver output first passes through a two-flop synchronizer. A counter measures consecutive low samples, restarts on any high sample and stops at the limit. A sample that is still low once the count has reached the limit sets a sticky flag. From then on, both the received and the transmitted bit are inverted through XOR. Only the power-on or hot-swap reset clears the flag. The limit is an input given in clock cycles, equal to (longest zero run + guard bits) times the clock frequency divided by the slowest data rate.

Top module: `bus_polarity_latch`

## Requirements
- R1: While `por_n` is low, `inverted` is 0 and `rx_out` is 1. A new reset clears a flag that was set earlier.
- R2: `rx_out` equals `rx_raw` delayed by two clock edges, XORed with `inverted`.
- R3: `tx_out` equals `tx_in` XORed with `inverted`, with no register in the path.
- R4: A run of `limit` or fewer consecutive low synchronized samples leaves `inverted` at 0.
- R5: `inverted` rises on the clock edge that sees the (`limit`+1)-th consecutive low synchronized sample. When `rx_raw` first goes low just before edge 0, that is edge `limit`+2.
- R6: A single high synchronized sample restarts the low count, so short runs separated by highs never add up.
- R7: Once set, `inverted` stays 1 through any later line activity until `por_n` is asserted.
- R8: With `limit` = 0, one low synchronized sample is enough to set `inverted`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on / hot-swap reset |
| rx_raw | input | 1 | Receiver output from the line transceiver (asynchronous) |
| tx_in | input | 1 | Transmit bit from the node's serial logic |
| limit | input | CNT_W | Failsafe low-time limit in clock cycles |
| rx_out | output | 1 | Synchronized, polarity-corrected receive bit |
| tx_out | output | 1 | Polarity-corrected transmit bit to the transceiver |
| inverted | output | 1 | Sticky wrong-polarity flag |

## Verification
The bench builds the block with `CNT_W` = 8 and drives `limit` at 10, then at 0. A limit that small makes the exact trip edge observable within a few cycles. It also allows a pulse of exactly `limit` lows and a burst of such pulses separated by one high cycle, which together exercise the boundary and the counter restart. The zero limit reaches the single-sample boundary, and a second reset shows that the flag clears.

// File: rtl/bus_polarity_latch.sv
module bus_polarity_latch #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rx_raw,
  input  logic             tx_in,
  input  logic [CNT_W-1:0] limit,
  output logic             rx_out,
  output logic             tx_out,
  output logic             inverted
);

  logic [1:0]       sync;
  logic [CNT_W-1:0] low_cnt;
  logic             rx_s;

  assign rx_s = sync[1];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sync <= 2'b11;
    else        sync <= {sync[0], rx_raw};
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      low_cnt  <= '0;
      inverted <= 1'b0;
    end else if (rx_s) begin
      low_cnt  <= '0;
    end else if (low_cnt >= limit) begin
      inverted <= 1'b1;
    end else begin
      low_cnt  <= low_cnt + 1'b1;
    end
  end

  assign rx_out = rx_s ^ inverted;
  assign tx_out = tx_in ^ inverted;

endmodule

module bus_polarity_latch_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             por_n,
  input logic             rx_raw,
  input logic             tx_in,
  input logic [CNT_W-1:0] limit,
  input logic             rx_out,
  input logic             tx_out,
  input logic             inverted
);

  logic [CNT_W:0] lowrun;
  logic [1:0]     age;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lowrun <= '0;
      age    <= '0;
    end else begin
      if (age != 2'd3) age <= age + 1'b1;
      if (rx_raw)              lowrun <= '0;
      else if (lowrun != '1)   lowrun <= lowrun + 1'b1;
    end
  end

  a_r2_rx_path: assert property (@(posedge clk) disable iff (!por_n)
    (age >= 2'd2) |-> (rx_out == ($past(rx_raw, 2) ^ inverted)));

  a_r3_tx_clean: assert property (@(posedge clk) disable iff (!por_n)
    !inverted |-> (tx_out == tx_in));

  a_r4_no_early_set: assert property (@(posedge clk) disable iff (!por_n)
    (!inverted && ($past(lowrun) <= {1'b0, limit})) |=> !inverted);

  a_r5_set_on_long_low: assert property (@(posedge clk) disable iff (!por_n)
    ($past(lowrun) > {1'b0, limit}) |=> inverted);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!por_n)
    inverted |=> inverted);

endmodule

bind bus_polarity_latch bus_polarity_latch_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .por_n(por_n), .rx_raw(rx_raw), .tx_in(tx_in), .limit(limit),
  .rx_out(rx_out), .tx_out(tx_out), .inverted(inverted)
);

// File: tb/bus_polarity_latch_test.sv
module bus_polarity_latch_test;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic rx_raw = 1'b1;
  logic tx_in = 1'b0;
  logic [CNT_W-1:0] limit = 8'd10;
  logic rx_out, tx_out, inverted;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string tag;
    logic  erx;
    logic  etx;
    logic  eflag;
  } item_t;

  item_t sb[$];

  bus_polarity_latch #(.CNT_W(CNT_W)) uut (
    .clk(clk), .por_n(por_n), .rx_raw(rx_raw), .tx_in(tx_in), .limit(limit),
    .rx_out(rx_out), .tx_out(tx_out), .inverted(inverted)
  );

  always #5 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic erx, input logic etx, input logic eflag);
    item_t it;
    it.tag = tag; it.erx = erx; it.etx = etx; it.eflag = eflag;
    #1;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (rx_out !== it.erx || tx_out !== it.etx || inverted !== it.eflag) begin
          errors++;
          $display("FAIL %s: rx_out/tx_out/inverted = %b%b%b expected %b%b%b",
                   it.tag, rx_out, tx_out, inverted, it.erx, it.etx, it.eflag);
        end
      end
    end
  end

  initial begin
    step(3);
    expect_out("R1 reset state", 1'b1, 1'b0, 1'b0);
    tx_in = 1'b1;
    expect_out("R3 tx passes in reset", 1'b1, 1'b1, 1'b0);
    por_n = 1'b1;
    step(3);

    rx_raw = 1'b0;
    step(1);
    expect_out("R2 latency edge one", 1'b1, 1'b1, 1'b0);
    step(1);
    expect_out("R2 low after two edges", 1'b0, 1'b1, 1'b0);
    rx_raw = 1'b1;
    step(2);
    expect_out("R2 high after two edges", 1'b1, 1'b1, 1'b0);

    rx_raw = 1'b0;
    step(10);
    rx_raw = 1'b1;
    step(4);
    expect_out("R4 run equal to limit", 1'b1, 1'b1, 1'b0);

    for (int k = 0; k < 3; k++) begin
      rx_raw = 1'b0;
      step(10);
      rx_raw = 1'b1;
      step(1);
    end
    step(3);
    expect_out("R6 high sample restarts count", 1'b1, 1'b1, 1'b0);

    rx_raw = 1'b0;
    step(12);
    expect_out("R5 not yet at edge limit+1", 1'b0, 1'b1, 1'b0);
    step(1);
    expect_out("R5 set at edge limit+2", 1'b1, 1'b0, 1'b1);

    rx_raw = 1'b1;
    step(20);
    expect_out("R7 held through high idle", 1'b0, 1'b0, 1'b1);
    tx_in = 1'b0;
    expect_out("R3 tx inverted", 1'b0, 1'b1, 1'b1);
    rx_raw = 1'b0;
    step(2);
    expect_out("R2 rx inverted", 1'b1, 1'b1, 1'b1);
    step(30);
    expect_out("R7 held through long low", 1'b1, 1'b1, 1'b1);

    por_n = 1'b0;
    rx_raw = 1'b1;
    limit = 8'd0;
    expect_out("R1 reset clears flag", 1'b1, 1'b0, 1'b0);
    step(2);
    por_n = 1'b1;
    step(3);
    expect_out("R1 stays clear after release", 1'b1, 1'b0, 1'b0);

    rx_raw = 1'b0;
    step(1);
    rx_raw = 1'b1;
    step(1);
    expect_out("R8 before trip with zero limit", 1'b0, 1'b0, 1'b0);
    step(1);
    expect_out("R8 single low sample trips", 1'b0, 1'b1, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule